// File: doc/BRIEF.md
# Deferred column-write commit buffer

This block sits on the device side of a packetised memory channel and holds at most one pending column write for each memory device. A write command records only its bank and column. Its data and byte mask follow a fixed number of packet slots later and land in the same buffer entry. The entry is not written into the bank array at once. It is committed later, and the row it goes into is whatever row that bank has open at the moment of the commit. No row is stored with the write.

The commit is due a fixed number of slots after the write command. A slot whose command is a read to the same device postpones it, and the delay lasts for as many such slots as keep arriving. Any other slot content lets the commit proceed: a no-op, a read to another device, or a write to any device. A new write to another device therefore also flushes old entries. Data for a new write can reach a device whose entry is still pending and not committing in that slot. In that case the old write is lost and a sticky error flag is set for that device.

Time is counted in packet slots of `PKT_CLK` clocks. A free-running phase counter starts at the first clock after reset is released. Commands, write data and open rows are sampled only on the first clock of each slot.

Top module: `wrb_retire_buf`

## Requirements
- R1: While reset is asserted, and after it is released, `arr_we_o`, `pending_o` and `ovf_err_o` are all zero. The first rising clock edge after release opens slot 0, and every `PKT_CLK`-th edge after it opens the next slot.
- R2: `cmd_op_i` is encoded as 0 = no-op, 1 = read and 2 = write. A write stores `cmd_bank_i` and `cmd_col_i` in the slot of the command. It stores `wr_data_i` and `wr_mask_i` from the slot `T_CWD` slots later. The commit presents exactly those bank, column, data and mask values.
- R3: A device's commit fires in the first slot that is at least `T_RTR` slots after its write command and that carries no read to the same device. The commit is reported as a one-clock pulse on that device's `arr_we_o` bit, seen on the clock after the slot's opening edge.
- R4: A read to the same device postpones the commit for every slot that carries such a read, with no limit on how many slots.
- R5: The committed row is the `row_open_i` field for (device, stored bank), as sampled in the commit slot. The field for device d and bank b sits at bit offset (d*NUM_BANK+b)*ROW_W. If that field changed after the write, the new row is used.
- R6: A read addressed to a different device does not postpone a due commit.
- R7: A write command to any device does not postpone a due commit. When new data reaches a device whose entry commits in that same slot, the old entry commits, the new one loads, and no error is raised.
- R8: When new data loads into a device whose entry is pending and not committing in that slot, the old entry is discarded and never committed. That device's `ovf_err_o` bit then goes high and stays high until reset.
- R9: `pending_o[d]` rises with the load of write data and falls on the commit clock, unless a new load happens in the same slot.
- R10: Command inputs that are present only on clocks other than a slot's first clock have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_op_i | input | 2 | Slot command: 0 no-op, 1 read, 2 write |
| cmd_dev_i | input | DEV_W | Target device of the command |
| cmd_bank_i | input | BANK_W | Bank of the command |
| cmd_col_i | input | COL_W | Column of the command |
| wr_data_i | input | DATA_W | Write data, taken `T_CWD` slots after the write command |
| wr_mask_i | input | MASK_W | Byte mask taken with the write data |
| row_open_i | input | NUM_DEV*NUM_BANK*ROW_W | Open row of each bank of each device |
| arr_we_o | output | NUM_DEV | Commit strobe, one bit per device |
| arr_bank_o | output | NUM_DEV*BANK_W | Bank of the commit, per device |
| arr_row_o | output | NUM_DEV*ROW_W | Row of the commit, per device |
| arr_col_o | output | NUM_DEV*COL_W | Column of the commit, per device |
| arr_data_o | output | NUM_DEV*DATA_W | Data of the commit, per device |
| arr_mask_o | output | NUM_DEV*MASK_W | Mask of the commit, per device |
| pending_o | output | NUM_DEV | Uncommitted write held, per device |
| ovf_err_o | output | NUM_DEV | Sticky lost-write flag, per device |

## Verification
Every result of a slot is due on the clock right after that slot's opening edge: the commit pulse and its fields, and the updated pending and error flags. Write data counts from `T_CWD` slots after its command, and a commit counts from `T_RTR` slots after it. The bench drives each slot's inputs on a falling edge and updates its model in that step. It compares on the next falling edge. It then checks on each of the remaining clocks of the packet that the strobe is low and the pending flags have not moved, which also catches commands taken off the slot boundary.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } col_op_e;
endpackage

// File: rtl/wrb_slot_timer.sv
module wrb_slot_timer #(
  parameter int PKT_CLK = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic slot_o
);
  localparam int PH_W = (PKT_CLK > 1) ? $clog2(PKT_CLK) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PKT_CLK - 1);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                phase_q <= '0;
    else if (phase_q == PH_LAST) phase_q <= '0;
    else                        phase_q <= phase_q + 1'b1;
  end

  assign slot_o = (phase_q == '0);
endmodule

// File: rtl/wrb_cmd_delay.sv
// Carries write addresses forward until their data slot.
module wrb_cmd_delay #(
  parameter int DEPTH  = 1,
  parameter int DEV_W  = 1,
  parameter int BANK_W = 2,
  parameter int COL_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_i,
  input  logic              wr_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  output logic              vld_o,
  output logic [DEV_W-1:0]  dev_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o
);
  logic              vld_q  [DEPTH];
  logic [DEV_W-1:0]  dev_q  [DEPTH];
  logic [BANK_W-1:0] bank_q [DEPTH];
  logic [COL_W-1:0]  col_q  [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < DEPTH; s++) begin
        vld_q[s]  <= 1'b0;
        dev_q[s]  <= '0;
        bank_q[s] <= '0;
        col_q[s]  <= '0;
      end
    end else if (slot_i) begin
      vld_q[0]  <= wr_i;
      dev_q[0]  <= dev_i;
      bank_q[0] <= bank_i;
      col_q[0]  <= col_i;
      for (int s = 1; s < DEPTH; s++) begin
        vld_q[s]  <= vld_q[s-1];
        dev_q[s]  <= dev_q[s-1];
        bank_q[s] <= bank_q[s-1];
        col_q[s]  <= col_q[s-1];
      end
    end
  end

  assign vld_o  = vld_q[DEPTH-1];
  assign dev_o  = dev_q[DEPTH-1];
  assign bank_o = bank_q[DEPTH-1];
  assign col_o  = col_q[DEPTH-1];
endmodule

// File: rtl/wrb_dev_buf.sv
// One device's deferred write entry.
module wrb_dev_buf #(
  parameter int NUM_BANK = 4,
  parameter int ROW_W    = 6,
  parameter int COL_W    = 5,
  parameter int DATA_W   = 16,
  parameter int MASK_W   = 2,
  parameter int T_RTR    = 2,
  parameter int T_CWD    = 1,
  localparam int BANK_W  = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1,
  localparam int AGE_W   = $clog2(T_RTR + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      slot_i,
  input  logic                      rd_hit_i,
  input  logic                      ld_i,
  input  logic [BANK_W-1:0]         ld_bank_i,
  input  logic [COL_W-1:0]          ld_col_i,
  input  logic [DATA_W-1:0]         ld_data_i,
  input  logic [MASK_W-1:0]         ld_mask_i,
  input  logic [NUM_BANK*ROW_W-1:0] rows_i,
  output logic                      we_o,
  output logic [BANK_W-1:0]         bank_o,
  output logic [ROW_W-1:0]          row_o,
  output logic [COL_W-1:0]          col_o,
  output logic [DATA_W-1:0]         data_o,
  output logic [MASK_W-1:0]         mask_o,
  output logic                      pend_o,
  output logic                      err_o
);
  localparam logic [AGE_W-1:0] AGE_DUE  = AGE_W'(T_RTR);
  localparam logic [AGE_W-1:0] AGE_LOAD = AGE_W'(T_CWD + 1);

  logic              pend_q, err_q;
  logic [AGE_W-1:0]  age_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] data_q;
  logic [MASK_W-1:0] mask_q;
  logic [ROW_W-1:0]  row_sel;
  logic              due, retire;

  assign due     = pend_q && (age_q >= AGE_DUE);
  assign retire  = slot_i && due && !rd_hit_i;
  assign row_sel = rows_i[bank_q*ROW_W +: ROW_W];

  // entry state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      err_q  <= 1'b0;
      age_q  <= '0;
      bank_q <= '0;
      col_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else if (slot_i) begin
      if (ld_i) begin
        pend_q <= 1'b1;
        age_q  <= AGE_LOAD;
        bank_q <= ld_bank_i;
        col_q  <= ld_col_i;
        data_q <= ld_data_i;
        mask_q <= ld_mask_i;
        if (pend_q && !retire) err_q <= 1'b1;
      end else begin
        if (retire) pend_q <= 1'b0;
        if (pend_q && age_q < AGE_DUE) age_q <= age_q + 1'b1;
      end
    end
  end

  // commit port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      bank_o <= '0;
      row_o  <= '0;
      col_o  <= '0;
      data_o <= '0;
      mask_o <= '0;
    end else begin
      we_o <= retire;
      if (retire) begin
        bank_o <= bank_q;
        row_o  <= row_sel;
        col_o  <= col_q;
        data_o <= data_q;
        mask_o <= mask_q;
      end
    end
  end

  assign pend_o = pend_q;
  assign err_o  = err_q;
endmodule

// File: rtl/wrb_retire_buf.sv
module wrb_retire_buf
  import wrb_pkg::*;
#(
  parameter int NUM_DEV  = 2,
  parameter int NUM_BANK = 4,
  parameter int ROW_W    = 6,
  parameter int COL_W    = 5,
  parameter int DATA_W   = 16,
  parameter int MASK_W   = 2,
  parameter int PKT_CLK  = 4,
  parameter int T_RTR    = 2,
  parameter int T_CWD    = 1,
  localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int BANK_W  = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1,
  localparam int ROWS_W  = NUM_BANK * ROW_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [1:0]                  cmd_op_i,
  input  logic [DEV_W-1:0]            cmd_dev_i,
  input  logic [BANK_W-1:0]           cmd_bank_i,
  input  logic [COL_W-1:0]            cmd_col_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic [MASK_W-1:0]           wr_mask_i,
  input  logic [NUM_DEV*ROWS_W-1:0]   row_open_i,
  output logic [NUM_DEV-1:0]          arr_we_o,
  output logic [NUM_DEV*BANK_W-1:0]   arr_bank_o,
  output logic [NUM_DEV*ROW_W-1:0]    arr_row_o,
  output logic [NUM_DEV*COL_W-1:0]    arr_col_o,
  output logic [NUM_DEV*DATA_W-1:0]   arr_data_o,
  output logic [NUM_DEV*MASK_W-1:0]   arr_mask_o,
  output logic [NUM_DEV-1:0]          pending_o,
  output logic [NUM_DEV-1:0]          ovf_err_o
);
  col_op_e           op;
  logic              slot;
  logic              dly_vld;
  logic [DEV_W-1:0]  dly_dev;
  logic [BANK_W-1:0] dly_bank;
  logic [COL_W-1:0]  dly_col;

  assign op = col_op_e'(cmd_op_i);

  wrb_slot_timer #(.PKT_CLK(PKT_CLK)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_o (slot)
  );

  wrb_cmd_delay #(
    .DEPTH (T_CWD),
    .DEV_W (DEV_W),
    .BANK_W(BANK_W),
    .COL_W (COL_W)
  ) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_i (slot),
    .wr_i   (op == OP_WR),
    .dev_i  (cmd_dev_i),
    .bank_i (cmd_bank_i),
    .col_i  (cmd_col_i),
    .vld_o  (dly_vld),
    .dev_o  (dly_dev),
    .bank_o (dly_bank),
    .col_o  (dly_col)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic rd_hit, ld;
    assign rd_hit = (op == OP_RD) && (cmd_dev_i == DEV_W'(d));
    assign ld     = slot && dly_vld && (dly_dev == DEV_W'(d));

    wrb_dev_buf #(
      .NUM_BANK(NUM_BANK),
      .ROW_W   (ROW_W),
      .COL_W   (COL_W),
      .DATA_W  (DATA_W),
      .MASK_W  (MASK_W),
      .T_RTR   (T_RTR),
      .T_CWD   (T_CWD)
    ) u_buf (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .slot_i    (slot),
      .rd_hit_i  (rd_hit),
      .ld_i      (ld),
      .ld_bank_i (dly_bank),
      .ld_col_i  (dly_col),
      .ld_data_i (wr_data_i),
      .ld_mask_i (wr_mask_i),
      .rows_i    (row_open_i[d*ROWS_W +: ROWS_W]),
      .we_o      (arr_we_o[d]),
      .bank_o    (arr_bank_o[d*BANK_W +: BANK_W]),
      .row_o     (arr_row_o[d*ROW_W +: ROW_W]),
      .col_o     (arr_col_o[d*COL_W +: COL_W]),
      .data_o    (arr_data_o[d*DATA_W +: DATA_W]),
      .mask_o    (arr_mask_o[d*MASK_W +: MASK_W]),
      .pend_o    (pending_o[d]),
      .err_o     (ovf_err_o[d])
    );
  end
endmodule

// File: rtl/wrb_retire_buf_chk.sv
module wrb_retire_buf_chk #(
  parameter int NUM_DEV = 2,
  parameter int DEV_W   = 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         cmd_op_i,
  input logic [DEV_W-1:0]   cmd_dev_i,
  input logic [NUM_DEV-1:0] arr_we_o,
  input logic [NUM_DEV-1:0] pending_o,
  input logic [NUM_DEV-1:0] ovf_err_o
);
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|arr_we_o) |=> !(|arr_we_o)); // R3

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_chk
    AST_NO_COMMIT_ON_OWN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arr_we_o[d] |-> !($past(cmd_op_i) == 2'd1 && $past(cmd_dev_i) == DEV_W'(d))); // R4
    AST_COMMIT_FROM_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(arr_we_o[d]) |-> $past(pending_o[d])); // R9
    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_err_o[d] |=> ovf_err_o[d]); // R8
    AST_ERR_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ovf_err_o[d]) |-> $past(pending_o[d])); // R8
  end
endmodule

bind wrb_retire_buf wrb_retire_buf_chk #(
  .NUM_DEV(NUM_DEV),
  .DEV_W  (DEV_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cmd_op_i (cmd_op_i),
  .cmd_dev_i(cmd_dev_i),
  .arr_we_o (arr_we_o),
  .pending_o(pending_o),
  .ovf_err_o(ovf_err_o)
);

// File: tb/wrb_retire_buf_tb.sv
module wrb_retire_buf_tb;
  localparam int NDEV = 2, NBANK = 4, ROW_W = 6, COL_W = 5, DATA_W = 16, MASK_W = 2;
  localparam int PKT = 4, T_RTR = 2, T_CWD = 1, BANK_W = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0]              cmd_op = '0;
  logic [0:0]              cmd_dev = '0;
  logic [BANK_W-1:0]       cmd_bank = '0;
  logic [COL_W-1:0]        cmd_col = '0;
  logic [DATA_W-1:0]       wr_data = '0;
  logic [MASK_W-1:0]       wr_mask = '0;
  logic [NDEV*NBANK*ROW_W-1:0] row_open;
  logic [ROW_W-1:0]        rows [NDEV][NBANK];
  logic [NDEV-1:0]         we, pend, err;
  logic [NDEV*BANK_W-1:0]  o_bank;
  logic [NDEV*ROW_W-1:0]   o_row;
  logic [NDEV*COL_W-1:0]   o_col;
  logic [NDEV*DATA_W-1:0]  o_data;
  logic [NDEV*MASK_W-1:0]  o_mask;

  always #2 clk = ~clk;

  always_comb
    for (int d = 0; d < NDEV; d++)
      for (int b = 0; b < NBANK; b++)
        row_open[(d*NBANK+b)*ROW_W +: ROW_W] = rows[d][b];

  wrb_retire_buf u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_op_i(cmd_op), .cmd_dev_i(cmd_dev),
    .cmd_bank_i(cmd_bank), .cmd_col_i(cmd_col), .wr_data_i(wr_data), .wr_mask_i(wr_mask),
    .row_open_i(row_open), .arr_we_o(we), .arr_bank_o(o_bank), .arr_row_o(o_row),
    .arr_col_o(o_col), .arr_data_o(o_data), .arr_mask_o(o_mask),
    .pending_o(pend), .ovf_err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  // reference model
  int m_pend[NDEV], m_age[NDEV], m_bank[NDEV], m_col[NDEV], m_data[NDEV], m_mask[NDEV], m_err[NDEV];
  int e_we[NDEV], e_bank[NDEV], e_row[NDEV], e_col[NDEV], e_data[NDEV], e_mask[NDEV];
  int q_v[$], q_dev[$], q_bank[$], q_col[$];

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step(int op, int dev, int bank, int col, int data, int mask);
    int ov, odev, obank, ocol;
    ov = q_v.pop_front(); odev = q_dev.pop_front();
    obank = q_bank.pop_front(); ocol = q_col.pop_front();
    for (int d = 0; d < NDEV; d++) begin
      e_we[d] = 0;
      if (m_pend[d] != 0 && m_age[d] >= T_RTR && !(op == 1 && dev == d)) begin
        e_we[d] = 1;
        e_bank[d] = m_bank[d]; e_row[d] = int'(rows[d][m_bank[d]]);
        e_col[d] = m_col[d]; e_data[d] = m_data[d]; e_mask[d] = m_mask[d];
        m_pend[d] = 0;
      end
      if (m_age[d] < T_RTR) m_age[d]++;
    end
    if (ov != 0) begin
      if (m_pend[odev] != 0) m_err[odev] = 1;
      m_pend[odev] = 1; m_age[odev] = T_CWD + 1;
      m_bank[odev] = obank; m_col[odev] = ocol; m_data[odev] = data; m_mask[odev] = mask;
    end
    q_v.push_back(op == 2 ? 1 : 0); q_dev.push_back(dev);
    q_bank.push_back(bank); q_col.push_back(col);
  endtask

  task automatic run_slot(int op, int dev, int bank, int col, int data, int mask, bit junk);
    cmd_op = 2'(op); cmd_dev = 1'(dev); cmd_bank = BANK_W'(bank); cmd_col = COL_W'(col);
    wr_data = DATA_W'(data); wr_mask = MASK_W'(mask);
    model_step(op, dev, bank, col, data, mask);
    @(posedge clk); @(negedge clk);
    for (int d = 0; d < NDEV; d++) begin
      check($sformatf("R3 strobe dev%0d", d), int'(we[d]), e_we[d]);
      if (e_we[d] != 0) begin
        check($sformatf("R2 bank dev%0d", d), int'(o_bank[d*BANK_W +: BANK_W]), e_bank[d]);
        check($sformatf("R2 col dev%0d", d), int'(o_col[d*COL_W +: COL_W]), e_col[d]);
        check($sformatf("R2 data dev%0d", d), int'(o_data[d*DATA_W +: DATA_W]), e_data[d]);
        check($sformatf("R2 mask dev%0d", d), int'(o_mask[d*MASK_W +: MASK_W]), e_mask[d]);
        check($sformatf("R5 row dev%0d", d), int'(o_row[d*ROW_W +: ROW_W]), e_row[d]);
      end
      check($sformatf("R9 pending dev%0d", d), int'(pend[d]), m_pend[d]);
      check($sformatf("R8 error dev%0d", d), int'(err[d]), m_err[d]);
    end
    for (int i = 0; i < PKT - 1; i++) begin
      if (junk && i == 0) begin  // off-boundary write, R10
        cmd_op = 2'd2; cmd_dev = 1'b1; cmd_bank = 2'd3; cmd_col = 5'd31;
      end
      @(posedge clk); @(negedge clk);
      check("R3 strobe width", int'(we), 0);
      check("R10 pending steady", int'(pend), m_pend[0] + 2*m_pend[1]);
    end
  endtask

  initial begin
    #(4ns * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int d = 0; d < NDEV; d++) begin
      m_pend[d] = 0; m_age[d] = 0; m_err[d] = 0; m_bank[d] = 0;
      m_col[d] = 0; m_data[d] = 0; m_mask[d] = 0;
      for (int b = 0; b < NBANK; b++) rows[d][b] = ROW_W'(d*8 + b + 1);
    end
    for (int i = 0; i < T_CWD; i++) begin
      q_v.push_back(0); q_dev.push_back(0); q_bank.push_back(0); q_col.push_back(0);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 strobe in reset", int'(we), 0);
    check("R1 pending in reset", int'(pend), 0);
    check("R1 error in reset", int'(err), 0);
    rst_ni = 1'b1;
    run_slot(0, 0, 0, 0, 0, 0, 0);

    // R2 R3 R5: plain write commits T_RTR slots later into the open row
    rows[0][1] = 6'd37;
    run_slot(2, 0, 1, 3, 0, 0, 0);
    run_slot(0, 0, 0, 0, 16'hA5A5, 2'b01, 0);
    run_slot(0, 0, 0, 0, 0, 0, 0);
    run_slot(0, 0, 0, 0, 0, 0, 0);

    // R4 R5 R9: same-device reads hold the commit; row changes meanwhile
    run_slot(2, 0, 2, 7, 0, 0, 0);
    run_slot(0, 0, 0, 0, 16'h1234, 2'b11, 0);
    run_slot(1, 0, 1, 1, 0, 0, 0);
    run_slot(1, 0, 3, 2, 0, 0, 0);
    rows[0][2] = 6'd50;
    run_slot(1, 0, 0, 4, 0, 0, 0);
    run_slot(1, 0, 2, 5, 0, 0, 0);
    run_slot(0, 0, 0, 0, 0, 0, 0);

    // R6: read to the other device does not hold dev0
    run_slot(2, 0, 0, 1, 0, 0, 0);
    run_slot(0, 0, 0, 0, 16'hBEEF, 2'b10, 0);
    run_slot(1, 1, 2, 9, 0, 0, 0);

    // R7: write to another device flushes dev0 in its slot
    run_slot(2, 0, 3, 2, 0, 0, 0);
    run_slot(0, 0, 0, 0, 16'h0F0F, 2'b01, 0);
    run_slot(2, 1, 1, 4, 0, 0, 0);
    run_slot(0, 0, 0, 0, 16'h7777, 2'b11, 0);
    run_slot(0, 0, 0, 0, 0, 0, 0);

    // R7: same device, old entry due as new data arrives
    run_slot(2, 1, 2, 5, 0, 0, 0);
    run_slot(2, 1, 3, 6, 16'h1111, 2'b01, 0);
    run_slot(0, 0, 0, 0, 16'h2222, 2'b10, 0);
    run_slot(0, 0, 0, 0, 0, 0, 0);
    run_slot(0, 0, 0, 0, 0, 0, 0);

    // R10: commands off the slot boundary are ignored
    run_slot(0, 0, 0, 0, 0, 0, 1);
    run_slot(0, 0, 0, 0, 0, 0, 1);

    // R8: read forces overwrite of dev0's pending entry
    run_slot(2, 0, 1, 8, 0, 0, 0);
    run_slot(2, 0, 2, 9, 16'hAAAA, 2'b01, 0);
    run_slot(1, 0, 0, 0, 16'hCCCC, 2'b11, 0);
    run_slot(0, 0, 0, 0, 0, 0, 0);
    run_slot(0, 0, 0, 0, 0, 0, 0);
    run_slot(0, 0, 0, 0, 0, 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule